// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that completes one instruction per clock. It runs nine instructions: word load, word store, add, subtract, bitwise AND, bitwise OR, signed set-less-than, branch-on-equal and an unconditional jump. The core holds a program counter, a 32-entry register file, an instruction memory and a data memory. Both memories are internal word arrays that the environment fills before reset is released. On each rising edge the core updates the program counter, the register file and the data memory together. The new values for all three come from combinational logic that works on the instruction fetched in the same cycle.

Control is decoded in two levels. The opcode picks a 2-bit operation class. That class either forces the ALU to add (memory access) or subtract (branch compare), or it passes control to a decode of the function field (register-format). The branch and jump immediates count words, so the core shifts them left by two before use. The only outputs are debug views: the current program counter, and one register chosen by a select input.

Top module: `rsc_core`

## Requirements
- R1: While synchronous reset is high at a rising edge, the program counter becomes 0 and every register becomes 0.
- R2: Every instruction other than a taken branch or a jump leaves the program counter at its old value plus 4.
- R3: Opcode 000000 is register-format: rs in bits 25:21, rt in 20:16, rd in 15:11, funct in 5:0. Funct 100000 writes rs+rt to rd, 100010 writes rs-rt, 100100 writes rs AND rt, and 100101 writes rs OR rt.
- R4: Funct 101010 writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 100011 writes to rt the data word at byte address rs plus the sign-extended 16-bit offset in bits 15:0. That word is data word (address / 4).
- R6: Opcode 101011 stores rt at the byte address formed as in R5. A later load from that address returns the stored word.
- R7: Opcode 000100 compares rs and rt. When they are equal, the next program counter is PC+4 plus the sign-extended offset times 4. Otherwise it is PC+4.
- R8: Opcode 000010 sets the next program counter to the top 4 bits of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R9: Register 0 always reads as 0, and writes to it have no effect.
- R10: Any other opcode writes no register and no memory, and the program counter advances by 4.
- R11: The debug output combinationally shows the register chosen by the 5-bit debug select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_sel | input | 5 | Register number for the debug read-back |
| pc_out | output | 32 | Current program counter (byte address) |
| dbg_val | output | 32 | Contents of the register chosen by dbg_sel |

## Verification
A decode fault or an ALU fault corrupts the register written by the faulty instruction. That value shows on the debug read-back at the next falling edge. Where the value feeds a later address or branch compare, it also shows on the program counter. A fault in next-PC selection shows on the program counter one clock after the branch, jump or unrecognised instruction, because the program counter is checked every cycle. A spurious store shows up only when a later load reads the damaged word into a register.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int REG_AW = $clog2(NREGS);

    localparam logic [5:0] OPC_RFMT  = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JMP   = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_BR  = 2'b01,
        CLS_REG = 2'b10
    } op_class_e;

    typedef struct packed {
        logic      dst_is_rd;
        logic      b_is_imm;
        logic      wb_from_mem;
        logic      reg_wr;
        logic      mem_rd;
        logic      mem_wr;
        logic      is_branch;
        logic      is_jump;
        op_class_e cls;
    } ctrl_t;

endpackage

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
    import rsc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_op_e    alu_sel
);

    // First level: opcode to control lines and operation class
    always_comb begin
        ctl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
                reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                is_branch: 1'b0, is_jump: 1'b0, cls: CLS_MEM};
        case (opcode)
            OPC_RFMT: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_wr    = 1'b1;
                ctl.cls       = CLS_REG;
            end
            OPC_LOAD: begin
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_wr      = 1'b1;
                ctl.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctl.b_is_imm = 1'b1;
                ctl.mem_wr   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.cls       = CLS_BR;
            end
            OPC_JMP: begin
                ctl.is_jump = 1'b1;
            end
            default: ;
        endcase
    end

    // Second level: operation class (and funct) to ALU operation
    always_comb begin
        unique case (ctl.cls)
            CLS_MEM: alu_sel = ALU_ADD;
            CLS_BR:  alu_sel = ALU_SUB;
            CLS_REG: begin
                case (funct)
                    FN_SUB:  alu_sel = ALU_SUB;
                    FN_AND:  alu_sel = ALU_AND;
                    FN_OR:   alu_sel = ALU_OR;
                    FN_SLT:  alu_sel = ALU_SLT;
                    default: alu_sel = ALU_ADD;
                endcase
            end
            default: alu_sel = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
    import rsc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);

    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile
    import rsc_pkg::*;
#(
    parameter int N = NREGS,
    parameter int W = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_dbg
);

    logic [W-1:0] regs [N];

    // Entry 0 is never stored; entries 1..N-1 are plain registers
    assign regs[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (waddr == AW'(g)))
                regs[g] <= wdata;
        end
    end

    assign rd_a   = regs[ra_a];
    assign rd_b   = regs[ra_b];
    assign rd_dbg = regs[ra_dbg];

endmodule

// File: rtl/rsc_core.sv
module rsc_core
    import rsc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] dbg_sel,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   dbg_val
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    // Memories, filled from outside before reset is released
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    end

    logic [XLEN-1:0]   pc_q, pc_d, pc_plus4, br_tgt, j_tgt;
    logic [XLEN-1:0]   instr;
    logic [5:0]        opcode, funct;
    logic [REG_AW-1:0] rs, rt, rd, rf_waddr;
    logic [XLEN-1:0]   imm_sx, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
    logic              alu_zero, rf_we, dm_we;
    logic [DAW-1:0]    dm_idx;
    ctrl_t             ctl;
    alu_op_e           alu_sel;

    // Fetch and field split
    assign instr  = imem[pc_q[IAW+1:2]];
    assign opcode = instr[31:26];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign funct  = instr[5:0];
    assign imm_sx = {{16{instr[15]}}, instr[15:0]};

    rsc_ctrl u_ctrl (
        .opcode  (opcode),
        .funct   (funct),
        .ctl     (ctl),
        .alu_sel (alu_sel)
    );

    assign rf_waddr = ctl.dst_is_rd ? rd : rt;
    assign rf_we    = ctl.reg_wr;
    assign dm_we    = ctl.mem_wr;

    rsc_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (wb_data),
        .ra_a   (rs),
        .ra_b   (rt),
        .ra_dbg (dbg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_val)
    );

    assign alu_b = ctl.b_is_imm ? imm_sx : rt_val;

    rsc_alu u_alu (
        .op   (alu_sel),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory: word index from the byte address
    assign dm_idx   = alu_y[DAW+1:2];
    assign dm_rdata = ctl.mem_rd ? dmem[dm_idx] : '0;
    assign wb_data  = ctl.wb_from_mem ? dm_rdata : alu_y;

    always_ff @(posedge clk) begin
        if (!rst && dm_we)
            dmem[dm_idx] <= rt_val;
    end

    // Next program counter
    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
    assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctl.is_jump)
            pc_d = j_tgt;
        else if (ctl.is_branch && alu_zero)
            pc_d = br_tgt;
        else
            pc_d = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_out = pc_q;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], imm_sx[31:30], alu_y, pc_q};

endmodule

// File: rtl/rsc_core_chk.sv
module rsc_core_chk
    import rsc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   instr,
    input logic [XLEN-1:0]   rs_val,
    input logic [XLEN-1:0]   rt_val,
    input logic              rf_we,
    input logic              dm_we,
    input logic [REG_AW-1:0] dbg_sel,
    input logic [XLEN-1:0]   dbg_val
);

    logic [5:0]      op;
    logic            known_op, redirect;
    logic [XLEN-1:0] seq_pc, exp_br, exp_j;

    assign op       = instr[31:26];
    assign known_op = (op == OPC_RFMT) || (op == OPC_LOAD) || (op == OPC_STORE)
                   || (op == OPC_BEQ)  || (op == OPC_JMP);
    assign redirect = (op == OPC_JMP) || ((op == OPC_BEQ) && (rs_val == rt_val));
    assign seq_pc   = pc + 32'd4;
    assign exp_br   = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign exp_j    = {seq_pc[31:28], instr[25:0], 2'b00};

    a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == '0));

    a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> (pc == $past(seq_pc)));

    a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
        ((op == OPC_BEQ) && (rs_val == rt_val)) |=> (pc == $past(exp_br)));

    a_r8_jump: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JMP) |=> (pc == $past(exp_j)));

    a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == '0) |-> (dbg_val == '0));

    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!rf_we && !dm_we));

endmodule

bind rsc_core rsc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc_q),
    .instr   (instr),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .rf_we   (rf_we),
    .dm_we   (dm_we),
    .dbg_sel (dbg_sel),
    .dbg_val (dbg_val)
);

// File: tb/rsc_core_bench.sv
module rsc_core_bench;
    import rsc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] pc_out, dbg_val;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rsc_core u_rsc_core (
        .clk     (clk),
        .rst     (rst),
        .dbg_sel (dbg_sel),
        .pc_out  (pc_out),
        .dbg_val (dbg_val)
    );

    // Expected PC before each executed instruction, one entry per cycle
    localparam int NPC = 20;
    localparam logic [31:0] PC_EXP [NPC] = '{
        32'd0,  32'd4,  32'd8,  32'd12, 32'd16, 32'd20, 32'd24, 32'd28,
        32'd32, 32'd36, 32'd40, 32'd44, 32'd48, 32'd52, 32'd60, 32'd72,
        32'd76, 32'd80, 32'd84, 32'd84
    };

    // Expected register file once the program has settled
    localparam logic [31:0] REG_EXP [32] = '{
        32'h0,        32'h5,        32'hFFFF_FFF0, 32'hFFFF_FFF5,
        32'h15,       32'h5,        32'hFFFF_FFF5, 32'h1,
        32'h0,        32'h15,       32'h0,         32'h0,
        32'h1A,       32'h10,       32'hFFFF_FFF0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0
    };

    function automatic logic [31:0] enc_r(logic [4:0] s, logic [4:0] t,
                                          logic [4:0] d, logic [5:0] fn);
        return {6'b000000, s, t, d, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] s,
                                          logic [4:0] t, logic [15:0] imm);
        return {op, s, t, imm};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(int r, output logic [31:0] v);
        dbg_sel = 5'(r);
        #1;
        v = dbg_val;
    endtask

    task automatic load_program();
        u_rsc_core.imem[0]  = enc_i(6'b100011, 5'd0, 5'd1, 16'd4);     // lw r1,4(r0)
        u_rsc_core.imem[1]  = enc_i(6'b100011, 5'd0, 5'd2, 16'd8);     // lw r2,8(r0)
        u_rsc_core.imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);      // add
        u_rsc_core.imem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);      // sub
        u_rsc_core.imem[4]  = enc_r(5'd1, 5'd3, 5'd5, 6'b100100);      // and
        u_rsc_core.imem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'b100101);      // or
        u_rsc_core.imem[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'b101010);      // slt true
        u_rsc_core.imem[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'b101010);      // slt false
        u_rsc_core.imem[8]  = enc_r(5'd1, 5'd1, 5'd0, 6'b100000);      // add to r0
        u_rsc_core.imem[9]  = enc_i(6'b101011, 5'd0, 5'd4, 16'd12);    // sw r4,12(r0)
        u_rsc_core.imem[10] = enc_i(6'b100011, 5'd0, 5'd9, 16'd12);    // lw r9,12(r0)
        u_rsc_core.imem[11] = 32'hFC00_0000;                            // unknown opcode
        u_rsc_core.imem[12] = enc_i(6'b000100, 5'd1, 5'd2, 16'd2);     // beq not taken
        u_rsc_core.imem[13] = enc_i(6'b000100, 5'd1, 5'd5, 16'd1);     // beq taken -> 60
        u_rsc_core.imem[14] = enc_r(5'd1, 5'd1, 5'd10, 6'b100000);     // skipped
        u_rsc_core.imem[15] = {6'b000010, 26'd18};                      // j 72
        u_rsc_core.imem[16] = enc_r(5'd1, 5'd1, 5'd11, 6'b100000);     // skipped
        u_rsc_core.imem[17] = enc_r(5'd1, 5'd1, 5'd11, 6'b100000);     // skipped
        u_rsc_core.imem[18] = enc_r(5'd1, 5'd4, 5'd12, 6'b100000);     // add r12
        u_rsc_core.imem[19] = enc_r(5'd4, 5'd1, 5'd13, 6'b100010);     // r13 = 16
        u_rsc_core.imem[20] = enc_i(6'b100011, 5'd13, 5'd14, 16'hFFF8); // lw r14,-8(r13)
        u_rsc_core.imem[21] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);  // beq self loop
        u_rsc_core.dmem[1]  = 32'h0000_0005;
        u_rsc_core.dmem[2]  = 32'hFFFF_FFF0;
        u_rsc_core.dmem[3]  = 32'h0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        #1;
        load_program();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state (R1)
        check("R1", pc_out, 32'd0, "pc after reset");
        read_reg(1, v);
        check("R1", v, 32'd0, "r1 after reset");

        // Cycle-by-cycle program counter walk: R2 sequential, R7 branch, R8 jump, R10 no-op advance
        for (int i = 0; i < NPC; i++) begin
            check("R2/R7/R8/R10", pc_out, PC_EXP[i], $sformatf("pc at step %0d", i));
            @(posedge clk);
            @(negedge clk);
        end

        // Register file contents: R3 R4 R5 R6 R9 R11
        for (int r = 0; r < 32; r++) begin
            read_reg(r, v);
            check("R3/R4/R5/R6/R9/R11", v, REG_EXP[r], $sformatf("register %0d", r));
        end

        // Directed corner cases
        read_reg(0, v);
        check("R9", v, 32'd0, "r0 after write attempt");
        read_reg(7, v);
        check("R4", v, 32'd1, "signed slt negative vs positive");
        read_reg(9, v);
        check("R6", v, 32'h15, "load after store");
        read_reg(14, v);
        check("R5", v, 32'hFFFF_FFF0, "negative offset load");
        read_reg(10, v);
        check("R7", v, 32'd0, "instruction after taken branch skipped");
        read_reg(11, v);
        check("R8", v, 32'd0, "instructions after jump skipped");
        check("R7", pc_out, 32'd84, "self-loop holds");

        // Reset mid-run (R1)
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", pc_out, 32'd0, "pc after second reset");
        read_reg(12, v);
        check("R1", v, 32'd0, "r12 cleared by reset");
        rst = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule